// File: doc/BRIEF.md
# Triangle Tone Channel with Linear Counter

This block produces a stepped triangle waveform for a sound subsystem. Software programs it through a small byte-wide write port: a control byte (hold flag and linear reload), a period low byte, and a byte that carries the upper period bits and a note-length index. An 11-bit period timer runs on the block clock and moves a 32-step sequencer forward. Each step maps to a signed sample that ramps from 0 up to +16, back to 0, down to -16 and back to 0.

Two counters decide whether the channel sounds, and both are clocked by an external frame tick. The first is a 7-bit linear counter. The second is a length counter, loaded from an internal table of note lengths. Counting does not begin at the moment of a length write. It begins only after a programmable number of frame ticks have passed, which gives software time to finish writing its other registers.

A channel-enable input gates the whole channel. When it is low, the counters are kept cleared. The write port is a valid/ready interface whose ready output is always high. A write takes effect at the clock edge where valid is high, and the port never applies back-pressure.

Top module: `tri_channel`

## Requirements
- R1: After reset the sample output is 0, both counters are 0, the sequencer is at step 0 and wr_ready is 1.
- R2: Register writes use these addresses:
  - Address 0: bit 7 is the hold flag and bits 6:0 are the linear reload value.
  - Address 2: the period low byte.
  - Address 3: bits 2:0 are the period high bits and bits 7:3 are the length index.
  - Address 1: the write is accepted and has no effect.
- R3: While the channel is audible, the sequencer advances by exactly one step, modulo 32, once every ({high,low}+1) clock cycles.
- R4: The sample for step s is built in three stages, with a range of -16 to +16:
  - Start from 2*s[2:0].
  - If s[3] is 1, replace it with 16 minus that value.
  - If s[4] is 1, negate it.
  The held sample changes only when the sequencer advances.
- R5: When the period value {high,low}+1 is below 4, the sample is 0 and the sequencer does not move.
- R6: A write to address 3 while the channel is enabled does four things:
  - Loads the length counter from the table at index data[7:3]. Index 1 gives 254 and index 3 gives 2.
  - Loads the linear counter from the stored reload value.
  - Clears the started flag.
  - Arms the latency counter with LAT_TICKS.
- R7: While the started flag is clear and hold is 0, each frame tick decrements the latency counter. The tick on which it reaches 0 sets the started flag and also clocks the counters. While hold is 1, the counters never start.
- R8: Once started, each frame tick decrements a nonzero linear counter. A nonzero length counter decrements only while hold is 0.
- R9: A write to address 0 reloads the linear counter with data[6:0] only while the started flag is clear.
- R10: The sample is 0 whenever either counter is 0.
- R11: While ch_enable is low, the sample is 0 and both counters, the started flag and the latency counter are held at 0. A write to address 3 in that state loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also clocks the period timer |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_enable | input | 1 | Channel enable; low clears the counters |
| frame_tick | input | 1 | One-cycle pulse that clocks the latency, linear and length counters |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write acceptance, always 1 |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| sample | output | 6 | Signed two's-complement sample, -16 to +16 |

## Verification
The assertions assume that frame_tick and a write to address 0 never fall in the same cycle, because the block gives the write priority in that case. They also assume that a hold-flag change and a length write never share a cycle with a disable edge. The stimulus drives writes and ticks from separate tasks on falling edges, and each task completes before the next begins, so no write ever lands on a tick cycle. Period changes are made only while the channel is running at a known step spacing. The bench then measures the interval over two full steps, so that the step in which the timer was already counting is not measured.

// File: rtl/tri_pkg.sv
package tri_pkg;
  localparam int PER_W  = 11;
  localparam int LIN_W  = 7;
  localparam int LEN_W  = 8;
  localparam int IDX_W  = 5;
  localparam int STEP_W = 5;
  localparam int SMP_W  = 6;

  typedef struct packed {
    logic             hold;
    logic [LIN_W-1:0] lin_reload;
    logic [PER_W-1:0] period_raw;
    logic [IDX_W-1:0] len_idx;
  } tri_cfg_t;

  // note-length table: odd indices are computed, even ones come from two short rows
  function automatic logic [LEN_W-1:0] len_lookup(input logic [IDX_W-1:0] idx);
    logic [LEN_W-1:0] v;
    if (idx[0]) begin
      v = (idx == 5'd1) ? 8'd254 : {3'b000, idx} - 8'd1;
    end else begin
      case (idx[4:1])
        4'd0:  v = 8'd10;
        4'd1:  v = 8'd20;
        4'd2:  v = 8'd40;
        4'd3:  v = 8'd80;
        4'd4:  v = 8'd160;
        4'd5:  v = 8'd60;
        4'd6:  v = 8'd14;
        4'd7:  v = 8'd26;
        4'd8:  v = 8'd12;
        4'd9:  v = 8'd24;
        4'd10: v = 8'd48;
        4'd11: v = 8'd96;
        4'd12: v = 8'd192;
        4'd13: v = 8'd72;
        4'd14: v = 8'd16;
        default: v = 8'd32;
      endcase
    end
    return v;
  endfunction

  // triangle shape for one sequencer step
  function automatic logic signed [SMP_W-1:0] step_wave(input logic [STEP_W-1:0] s);
    logic [4:0] mag;
    logic signed [SMP_W-1:0] pos;
    mag = {1'b0, s[2:0], 1'b0};
    if (s[3]) mag = 5'd16 - mag;
    pos = $signed({1'b0, mag});
    return s[4] ? -pos : pos;
  endfunction
endpackage

// File: rtl/tri_regs.sv
module tri_regs
  import tri_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output tri_cfg_t   cfg,
  output logic       ld_all,
  output logic       ld_lin
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_PLO  = 2'd2;
  localparam logic [1:0] A_PHI  = 2'd3;

  assign ld_all = wr_valid && (wr_addr == A_PHI);
  assign ld_lin = wr_valid && (wr_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_valid) begin
      case (wr_addr)
        A_CTRL: begin
          cfg.hold       <= wr_data[7];
          cfg.lin_reload <= wr_data[LIN_W-1:0];
        end
        A_PLO: cfg.period_raw[7:0] <= wr_data;
        A_PHI: begin
          cfg.period_raw[PER_W-1:8] <= wr_data[2:0];
          cfg.len_idx               <= wr_data[7:3];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tri_gate.sv
module tri_gate
  import tri_pkg::*;
#(
  parameter int LAT_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             frame_tick,
  input  logic             ld_all,
  input  logic             ld_lin,
  input  logic [7:0]       wr_data,
  input  tri_cfg_t         cfg,
  output logic [LIN_W-1:0] lin_cnt,
  output logic [LEN_W-1:0] len_cnt,
  output logic             started,
  output logic             gate_open
);
  localparam int LAT_W = (LAT_TICKS < 1) ? 1 : $clog2(LAT_TICKS + 1);

  logic [LAT_W-1:0] lat_cnt;
  logic waiting, start_now, run;

  assign waiting   = frame_tick && !started && !cfg.hold;
  assign start_now = waiting && (lat_cnt <= LAT_W'(1));
  assign run       = frame_tick && (started || start_now);
  assign gate_open = en && (lin_cnt != '0) && (len_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      lin_cnt <= '0;
      len_cnt <= '0;
      started <= 1'b0;
      lat_cnt <= '0;
    end else if (ld_all) begin
      len_cnt <= len_lookup(wr_data[7:3]);
      lin_cnt <= cfg.lin_reload;
      started <= 1'b0;
      lat_cnt <= LAT_W'(LAT_TICKS);
    end else begin
      if (waiting) begin
        if (lat_cnt != '0) lat_cnt <= lat_cnt - LAT_W'(1);
        if (start_now) started <= 1'b1;
      end
      if (ld_lin && !started)
        lin_cnt <= wr_data[LIN_W-1:0];
      else if (run && lin_cnt != '0)
        lin_cnt <= lin_cnt - LIN_W'(1);
      if (run && !cfg.hold && len_cnt != '0)
        len_cnt <= len_cnt - LEN_W'(1);
    end
  end
endmodule

// File: rtl/tri_seq.sv
module tri_seq
  import tri_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    gate_open,
  input  logic [PER_W-1:0]        period_raw,
  output logic [STEP_W-1:0]       step,
  output logic signed [SMP_W-1:0] held,
  output logic                    audible
);
  localparam logic [PER_W-1:0] MIN_RAW = PER_W'(3);

  logic [PER_W-1:0]  timer;
  logic [STEP_W-1:0] step_nx;

  assign audible = gate_open && (period_raw >= MIN_RAW);
  assign step_nx = step + STEP_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer <= '0;
      step  <= '0;
      held  <= '0;
    end else if (!audible) begin
      timer <= period_raw;
    end else if (timer == '0) begin
      timer <= period_raw;
      step  <= step_nx;
      held  <= step_wave(step_nx);
    end else begin
      timer <= timer - PER_W'(1);
    end
  end
endmodule

// File: rtl/tri_channel.sv
module tri_channel
  import tri_pkg::*;
#(
  parameter int LAT_TICKS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ch_enable,
  input  logic                    frame_tick,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [1:0]              wr_addr,
  input  logic [7:0]              wr_data,
  output logic signed [SMP_W-1:0] sample
);
  tri_cfg_t                cfg;
  logic                    ld_all, ld_lin, started, gate_open, audible;
  logic [LIN_W-1:0]        lin_cnt;
  logic [LEN_W-1:0]        len_cnt;
  logic [STEP_W-1:0]       step;
  logic signed [SMP_W-1:0] held;

  assign wr_ready = 1'b1;

  tri_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg), .ld_all(ld_all), .ld_lin(ld_lin)
  );

  tri_gate #(.LAT_TICKS(LAT_TICKS)) u_gate (
    .clk(clk), .rst_n(rst_n), .en(ch_enable), .frame_tick(frame_tick),
    .ld_all(ld_all), .ld_lin(ld_lin), .wr_data(wr_data), .cfg(cfg),
    .lin_cnt(lin_cnt), .len_cnt(len_cnt), .started(started), .gate_open(gate_open)
  );

  tri_seq u_seq (
    .clk(clk), .rst_n(rst_n), .gate_open(gate_open), .period_raw(cfg.period_raw),
    .step(step), .held(held), .audible(audible)
  );

  assign sample = audible ? held : '0;
endmodule

// File: rtl/tri_channel_chk.sv
module tri_channel_chk
  import tri_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ch_enable,
  input logic signed [SMP_W-1:0] sample,
  input logic [LIN_W-1:0]        lin_cnt,
  input logic [LEN_W-1:0]        len_cnt,
  input logic                    started,
  input logic [STEP_W-1:0]       step,
  input logic [PER_W-1:0]        period_raw,
  input logic                    hold,
  input logic                    ld_all
);
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step != $past(step)) |-> (step == $past(step) + STEP_W'(1)));

  a_r4_sample_range: assert property (@(posedge clk) disable iff (!rst_n)
    (sample >= -6'sd16) && (sample <= 6'sd16));

  a_r5_short_period_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (period_raw < PER_W'(3)) |=> $stable(step));

  a_r8_hold_keeps_length: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_enable && hold && !ld_all) |=> $stable(len_cnt));

  a_r10_zero_counter_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((lin_cnt == '0) || (len_cnt == '0)) |-> (sample == '0));

  a_r11_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_enable |=> ((lin_cnt == '0) && (len_cnt == '0) && !started));

  a_r11_disable_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_enable |-> (sample == '0));
endmodule

bind tri_channel tri_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .sample(sample),
  .lin_cnt(lin_cnt), .len_cnt(len_cnt), .started(started), .step(step),
  .period_raw(cfg.period_raw), .hold(cfg.hold), .ld_all(ld_all)
);

// File: tb/tb_tri_channel.sv
module tb_tri_channel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ch_enable = 1'b0;
  logic frame_tick = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic signed [5:0] sample;

  int n_checks = 0;
  int n_fail = 0;

  // expected samples for steps 1..31 then 0 (R4)
  localparam int EXP [32] = '{2, 4, 6, 8, 10, 12, 14, 16, 14, 12, 10, 8, 6, 4, 2, 0,
                              -2, -4, -6, -8, -10, -12, -14, -16, -14, -12, -10, -8, -6, -4, -2, 0};

  always #10 clk = ~clk;

  tri_channel #(.LAT_TICKS(2)) dut (
    .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .frame_tick(frame_tick),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .sample(sample)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // 1 when sample moves within 12 cycles
  task automatic probe_active(output bit act);
    logic signed [5:0] prev;
    prev = sample;
    act = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (sample != prev) act = 1'b1;
    end
  endtask

  task automatic probe_silent(output bit sil);
    sil = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (sample != 0) sil = 1'b0;
    end
  endtask

  // cycles until the sample changes (capped at 20)
  task automatic gap(output int n);
    logic signed [5:0] prev;
    prev = sample;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sample == prev && n < 20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    bit b;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sample == 0, "R1 reset sample", int'(sample), 0);
    check(wr_ready == 1'b1, "R1 R2 ready", int'(wr_ready), 1);

    // sustained tone: hold set, linear 127, period 4, length index 1
    ch_enable = 1'b1;
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h03);
    wr(2'd3, 8'h08);
    for (int i = 0; i < 32; i++) begin
      gap(n);
      check(int'(sample) == EXP[i], "R4 step value", int'(sample), EXP[i]);
      if (i > 0) check(n == 4, "R3 step spacing", n, 4);
    end
    ticks(6);
    probe_active(b);
    check(b, "R7 hold keeps tone", int'(b), 1);

    // period 8
    wr(2'd2, 8'h07);
    gap(n); gap(n); gap(n);
    check(n == 8, "R3 period 8 spacing", n, 8);
    // address 1 write ignored
    wr(2'd1, 8'hFF);
    gap(n); gap(n);
    check(n == 8, "R2 addr1 no effect", n, 8);

    // short period silences
    wr(2'd2, 8'h02);
    probe_silent(b);
    check(b, "R5 period below 4", int'(sample), 0);
    wr(2'd2, 8'h03);
    probe_active(b);
    check(b, "R5 period 4 sounds", int'(b), 1);

    // disable
    @(negedge clk);
    ch_enable = 1'b0;
    #1;
    check(sample == 0, "R11 disable silent", int'(sample), 0);
    wr(2'd3, 8'h08);
    @(negedge clk);
    ch_enable = 1'b1;
    probe_silent(b);
    check(b, "R11 cleared after re-enable", int'(sample), 0);

    // latency: linear 1, hold clear
    wr(2'd0, 8'h01);
    wr(2'd3, 8'h08);
    tick();
    probe_active(b);
    check(b, "R7 latency tick1 active", int'(b), 1);
    tick();
    probe_silent(b);
    check(b, "R7 R10 linear expired tick2", int'(sample), 0);

    // linear counter of 3
    wr(2'd0, 8'h03);
    wr(2'd3, 8'h08);
    ticks(3);
    probe_active(b);
    check(b, "R8 linear 3 after 3 ticks", int'(b), 1);
    tick();
    probe_silent(b);
    check(b, "R8 linear 3 after 4 ticks", int'(sample), 0);

    // reload before start
    wr(2'd0, 8'h01);
    wr(2'd3, 8'h08);
    wr(2'd0, 8'h05);
    ticks(5);
    probe_active(b);
    check(b, "R9 reload before start", int'(b), 1);
    tick();
    probe_silent(b);
    check(b, "R9 reloaded count ends", int'(sample), 0);

    // no reload after start
    wr(2'd0, 8'h02);
    wr(2'd3, 8'h08);
    ticks(2);
    wr(2'd0, 8'h7F);
    tick();
    probe_silent(b);
    check(b, "R9 no reload after start", int'(sample), 0);

    // length index 3 -> 2
    wr(2'd0, 8'h7F);
    wr(2'd3, 8'h18);
    ticks(2);
    probe_active(b);
    check(b, "R6 R8 length 2 after 2 ticks", int'(b), 1);
    tick();
    probe_silent(b);
    check(b, "R8 R10 length expired", int'(sample), 0);

    // hold keeps length
    wr(2'd0, 8'h81);
    wr(2'd3, 8'h18);
    ticks(5);
    probe_active(b);
    check(b, "R7 R8 hold keeps counters", int'(b), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule